// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus front-end of a small serial memory that answers on a two-wire open-drain bus. A fast system clock oversamples the serial clock and data lines and finds start and stop conditions. It shifts bytes in and out most significant bit first and drives acknowledge bits by pulling the data line low.

The first byte after a start carries the memory word address (upper seven bits) and a direction bit (bit 0, 0 = write, 1 = read). There is no separate select byte. Reads are served from an external 128 x 8 store through a combinational read port. Each received write byte goes out as a one-cycle request to a separate write-cycle controller. A one-cycle commit pulse marks the stop that ends a write. While that controller reports busy, the engine does not acknowledge the first byte, so a master can poll for completion.

Top module: `tws_slave`

## Requirements
- R1: After reset the engine is idle with `sda_pull_o` low (data line released) and no write request or commit pending.
- R2: When not busy, the engine acknowledges a first byte by holding `sda_pull_o` high during the ninth clock, in both directions.
- R3: Every data byte received in a write raises `wr_req_o` for exactly one cycle, carrying the byte and its word address, and is acknowledged.
- R4: Between written bytes, only the two low address bits advance: 4-byte page, address n*4+3 is followed by n*4, upper five bits kept.
- R5: A stop that ends a transfer in which at least one byte was written raises `wr_commit_o` for one cycle. A stop after a read or an unacknowledged first byte does not.
- R6: In a read, the byte at the addressed location is shifted out most significant bit first, starting after the falling clock edge that ends the acknowledge.
- R7: When the master acknowledges a read byte, the address advances by one across the whole array (127 is followed by 0) and the next byte follows.
- R8: After a read byte that the master leaves unacknowledged, the engine keeps the data line released for any further clocks until a start or stop.
- R9: While `wr_busy_i` is high at the end of the first byte, that byte is not acknowledged, later bytes of the transfer are ignored, and no write request is made. Once busy is low the same byte is acknowledged.
- R10: A start condition in the middle of a byte abandons it and begins reception of a new first byte.
- R11: `sda_pull_o` only becomes active while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| rd_addr_o | output | 7 | Word address presented to the store read port |
| rd_data_i | input | 8 | Store contents at `rd_addr_o` (combinational) |
| wr_busy_i | input | 1 | Write-cycle controller is busy |
| wr_req_o | output | 1 | One-cycle request to write one byte |
| wr_addr_o | output | 7 | Word address of the write request |
| wr_data_o | output | 8 | Data byte of the write request |
| wr_commit_o | output | 1 | One-cycle pulse at the stop that ends a write |

## Verification
Five patterns drive the bus. A five-byte write that starts one short of a page end shows whether the address wraps within the page or carries into the next page. Sequential reads across an area just written and across the top of the array show whether reads use the full-array increment rather than the page increment. A busy-then-idle poll of the same first byte shows that acknowledgement depends on busy alone. A start cut into a half-sent byte, followed by a clean read, shows that partial bits are discarded and do not shift the next address.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = DATA_W - 1;
    localparam int PAGE_W    = 2;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK,
        ST_WAIT
    } tws_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/tws_bus_sync.sv
module tws_bus_sync
    import tws_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/tws_addr_ctr.sv
module tws_addr_ctr #(
    parameter int AW = 7,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    input  logic          page_mode,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] nxt_full;
    logic [AW-1:0] nxt_page;

    assign nxt_full = addr + AW'(1);

    generate
        if (PW > 0 && PW < AW) begin : g_page
            assign nxt_page = {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
        end else begin : g_flat
            assign nxt_page = nxt_full;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc) begin
            addr <= page_mode ? nxt_page : nxt_full;
        end
    end

endmodule

// File: rtl/tws_slave.sv
module tws_slave
    import tws_pkg::*;
#(
    parameter int DW      = tws_pkg::DATA_W,
    parameter int PAGE_BW = tws_pkg::PAGE_W,
    parameter int SYNC_N  = tws_pkg::SYNC_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_pull_o,
    output logic [DW-2:0] rd_addr_o,
    input  logic [DW-1:0] rd_data_i,
    input  logic          wr_busy_i,
    output logic          wr_req_o,
    output logic [DW-2:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          wr_commit_o
);

    localparam int AW = DW - 1;
    localparam int CW = $clog2(DW + 1);

    bus_ev_t       ev;
    tws_state_e    st;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic [DW-1:0] ob;
    logic          rw;
    logic          ack_m;
    logic          wrote;
    logic          quiet;
    logic          byte_end;
    logic          a_load;
    logic          a_inc;
    logic          a_page;
    logic [AW-1:0] addr;

    tws_bus_sync #(.STAGES(SYNC_N)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign quiet    = ~ev.start & ~ev.stop;
    assign byte_end = ev.scl_fall & (cnt == CW'(DW));

    always_comb begin
        a_load = quiet & (st == ST_ADDR) & byte_end & ~wr_busy_i;
        a_page = (st == ST_WACK);
        a_inc  = quiet & (((st == ST_WACK) & ev.scl_fall) |
                          ((st == ST_RACK) & ev.scl_rise & ~ev.sda));
    end

    tws_addr_ctr #(.AW(AW), .PW(PAGE_BW)) i_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (a_load),
        .load_val  (sh[DW-1:1]),
        .inc       (a_inc),
        .page_mode (a_page),
        .addr      (addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            sh          <= '0;
            ob          <= '0;
            rw          <= 1'b0;
            ack_m       <= 1'b0;
            wrote       <= 1'b0;
            sda_pull_o  <= 1'b0;
            wr_req_o    <= 1'b0;
            wr_commit_o <= 1'b0;
        end else begin
            wr_req_o    <= 1'b0;
            wr_commit_o <= 1'b0;
            if (ev.stop) begin
                st          <= ST_IDLE;
                sda_pull_o  <= 1'b0;
                wr_commit_o <= wrote;
                wrote       <= 1'b0;
            end else if (ev.start) begin
                st         <= ST_ADDR;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
                wrote      <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_WDAT: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[DW-2:0], ev.sda};
                            cnt <= cnt + CW'(1);
                        end else if (byte_end) begin
                            if (st == ST_ADDR) begin
                                if (wr_busy_i) begin
                                    st <= ST_WAIT;
                                end else begin
                                    sda_pull_o <= 1'b1;
                                    rw         <= sh[0];
                                    st         <= ST_AACK;
                                end
                            end else begin
                                sda_pull_o <= 1'b1;
                                wr_req_o   <= 1'b1;
                                wrote      <= 1'b1;
                                st         <= ST_WACK;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                ob         <= rd_data_i;
                                sda_pull_o <= ~rd_data_i[DW-1];
                                st         <= ST_RDAT;
                            end else begin
                                sda_pull_o <= 1'b0;
                                st         <= ST_WDAT;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (ev.scl_fall) begin
                            sda_pull_o <= 1'b0;
                            cnt        <= '0;
                            st         <= ST_WDAT;
                        end
                    end
                    ST_RDAT: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + CW'(1);
                        end else if (ev.scl_fall) begin
                            if (cnt == CW'(DW)) begin
                                sda_pull_o <= 1'b0;
                                st         <= ST_RACK;
                            end else begin
                                ob         <= {ob[DW-2:0], 1'b0};
                                sda_pull_o <= ~ob[DW-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) begin
                            ack_m <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (ack_m) begin
                                ob         <= rd_data_i;
                                sda_pull_o <= ~rd_data_i[DW-1];
                                cnt        <= '0;
                                st         <= ST_RDAT;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: begin
                        sda_pull_o <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign rd_addr_o = addr;
    assign wr_addr_o = addr;
    assign wr_data_o = sh;

endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk
    import tws_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_pull_o,
    input logic       wr_req_o,
    input logic       wr_commit_o,
    input logic       wr_busy_i,
    input tws_state_e st
);

    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_pull_o && st == ST_IDLE && !wr_req_o && !wr_commit_o));

    // R11
    a_r11_pull_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_i);

    // R3
    a_r3_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |=> !wr_req_o);

    // R3
    a_r3_req_during_ack: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> (st == ST_WACK && sda_pull_o));

    // R5
    a_r5_commit_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_commit_o |=> !wr_commit_o);

    // R5
    a_r5_commit_to_idle: assert property (@(posedge clk) disable iff (rst)
        wr_commit_o |-> (st == ST_IDLE && !wr_req_o));

    // R9
    a_r9_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADDR && wr_busy_i) |=> (st != ST_AACK));

endmodule

bind tws_slave tws_slave_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_pull_o  (sda_pull_o),
    .wr_req_o    (wr_req_o),
    .wr_commit_o (wr_commit_o),
    .wr_busy_i   (wr_busy_i),
    .st          (st)
);

// File: tb/test_tws_slave.sv
module test_tws_slave;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic       sda_pull;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_req;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;
    logic       wr_commit;
    wire        sda_line = sda_m & ~sda_pull;

    logic [7:0]  mem [128];
    logic [14:0] exp_q [$];
    int checks = 0;
    int errors = 0;
    int n_req = 0;
    int n_commit = 0;

    always #2 clk = ~clk;

    assign rd_data = mem[rd_addr];

    tws_slave i_tws_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .wr_busy_i   (busy),
        .wr_req_o    (wr_req),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wt(Q);
        scl_m = 1'b1; wt(Q);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q / 2);
        b = sda_line; wt(Q - Q / 2);
        scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack_bit);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ack_bit);
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~master_ack);
    endtask

    // scoreboard monitor: write requests against expected queue
    always @(negedge clk) begin
        if (!rst && wr_commit) n_commit++;
        if (!rst && wr_req) begin
            n_req++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected write request", {wr_addr, wr_data}, 0);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                chk({wr_addr, wr_data} == e, "R3/R4 write request addr,data",
                    {wr_addr, wr_data}, e);
                mem[e[14:8]] = e[7:0];
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] d;
        int         c0;
        int         r0;
        for (int i = 0; i < 128; i++) mem[i] = init_val(i);
        wt(6);
        chk(sda_pull == 1'b0, "R1 released after reset", sda_pull, 0);
        chk(wr_req == 1'b0 && wr_commit == 1'b0, "R1 no request after reset",
            {wr_req, wr_commit}, 0);
        rst = 1'b0;
        wt(10);
        chk(sda_pull == 1'b0, "R1 idle released", sda_pull, 0);

        // page write at 0x06, five bytes: 06 07 04 05 06
        exp_q.push_back({7'h06, 8'hA1});
        exp_q.push_back({7'h07, 8'hA2});
        exp_q.push_back({7'h04, 8'hA3});
        exp_q.push_back({7'h05, 8'hA4});
        exp_q.push_back({7'h06, 8'hA5});
        bus_start();
        put_byte({7'h06, 1'b0}, a);
        chk(a == 1'b0, "R2 write address ack", a, 0);
        for (int k = 0; k < 5; k++) begin
            put_byte(8'hA1 + 8'(k), a);
            chk(a == 1'b0, "R3 data byte ack", a, 0);
        end
        c0 = n_commit;
        bus_stop();
        wt(4);
        chk(n_commit == c0 + 1, "R5 commit after write", n_commit - c0, 1);
        chk(exp_q.size() == 0, "R4 all page writes seen", exp_q.size(), 0);

        // sequential read 04..07, then nack
        bus_start();
        put_byte({7'h04, 1'b1}, a);
        chk(a == 1'b0, "R2 read address ack", a, 0);
        get_byte(1'b1, d); chk(d == 8'hA3, "R6 read @04", d, 8'hA3);
        get_byte(1'b1, d); chk(d == 8'hA4, "R7 read @05", d, 8'hA4);
        get_byte(1'b1, d); chk(d == 8'hA5, "R7 read @06", d, 8'hA5);
        get_byte(1'b0, d); chk(d == 8'hA2, "R7 read @07", d, 8'hA2);
        for (int k = 0; k < 9; k++) begin
            get_bit(a);
            chk(a == 1'b1, "R8 released after nack", a, 1);
        end
        c0 = n_commit;
        bus_stop();
        wt(4);
        chk(n_commit == c0, "R5 no commit after read", n_commit - c0, 0);

        // wrap at top of array
        bus_start();
        put_byte({7'h7E, 1'b1}, a);
        chk(a == 1'b0, "R2 read address ack high", a, 0);
        get_byte(1'b1, d); chk(d == init_val(126), "R6 read @7E", d, init_val(126));
        get_byte(1'b1, d); chk(d == init_val(127), "R7 read @7F", d, init_val(127));
        get_byte(1'b0, d); chk(d == init_val(0), "R7 wrap to 00", d, init_val(0));
        bus_stop();

        // busy: no ack, no write
        busy = 1'b1;
        r0 = n_req;
        c0 = n_commit;
        bus_start();
        put_byte({7'h10, 1'b0}, a);
        chk(a == 1'b1, "R9 no ack while busy", a, 1);
        put_byte(8'h5A, a);
        chk(a == 1'b1, "R9 data ignored while busy", a, 1);
        bus_stop();
        wt(4);
        chk(n_req == r0, "R9 no write request while busy", n_req - r0, 0);
        chk(n_commit == c0, "R9 no commit while busy", n_commit - c0, 0);
        busy = 1'b0;
        bus_start();
        put_byte({7'h10, 1'b0}, a);
        chk(a == 1'b0, "R9 ack once idle", a, 0);
        bus_stop();
        wt(4);
        chk(n_commit == c0, "R5 no commit without data", n_commit - c0, 0);

        // start in the middle of a byte
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        put_byte({7'h20, 1'b1}, a);
        chk(a == 1'b0, "R10 ack after restart", a, 0);
        get_byte(1'b0, d);
        chk(d == init_val(32), "R10 read after restart", d, init_val(32));
        bus_stop();
        wt(10);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule